// File: doc/BRIEF.md
# Memory-Resident Interrupt Flag Scanner

This block services interrupts that are reported through memory instead of through registers. Each interrupting unit owns two regions in a report area. The first is a source region, where one byte per unit is set. The second is a status region, where each unit has sixteen event bytes. When the host interrupt line pulses, the scanner walks a programmable list of engine units. For each enabled unit it reads the unit's source byte. If that byte is set, the scanner writes it back to zero. It then reads the unit's selected event byte in the status region and clears that byte as well. When both bytes were found set, the scanner raises a one-cycle dispatch strobe for that unit.

After the engine list, two controller units are handled: a primary controller, and then a secondary controller, which is handled only when it is present. Memory is reached through a single request port with a fixed read latency. Any flag byte that is nonzero but not 0xFF is still treated as set. It is also recorded as an anomaly, together with its address, and this record is held until software acknowledges it.

Top module: `memirq_scan`

## Requirements
- R1: Every byte found nonzero, at either level, is written back to 0x00 at the same address, right after the read that found it. The port never writes any other value.
- R2: A unit's status byte is read only after its source byte was found nonzero. When the source byte is zero, the status byte is left untouched and no strobe is raised.
- R3: A unit's source byte is at page + 0x400 + offset. Its status byte is at page + offset × 16 + event bit. Engines use `eng_bit` as the event bit, and both controllers use `ctl_bit`.
- R4: A unit's dispatch strobe pulses for one cycle when both its source and status bytes were set. At most one strobe is high at a time. Units are visited in a fixed order: enabled engines in ascending index, then the primary controller, then the secondary controller, which is visited only while `sec_present` is 1. Engines whose enable bit is 0 are skipped.
- R5: The page is `region_base` + instance × 4096 for engines while `per_inst` is 1, where the instance comes from `unit_inst`. Otherwise the page is `region_base`. Controllers always use `region_base`.
- R6: While `region_valid` is 0, an interrupt pulse starts no scan and causes no memory access.
- R7: A nonzero value other than 0xFF is still treated as set. If no anomaly is currently held, the scanner latches `err_flag` together with the offending value and its address.
- R8: A held anomaly, with its value and address, stays unchanged until `err_ack` clears it. Later anomalies do not overwrite it.
- R9: `busy` is high for the whole scan. Any number of pulses that arrive during a scan cause exactly one further full scan after it.
- R10: `mem_rdata` is taken exactly `RD_LAT` cycles after the cycle of the read request. No request is issued while the scanner is idle.
- R11: After reset, the scanner is idle: no request, no strobe, and no anomaly held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq | input | 1 | Host interrupt pulse |
| region_valid | input | 1 | Report area configured |
| per_inst | input | 1 | Select engine pages by instance |
| region_base | input | AW | Base address of page 0 |
| unit_en | input | NU | Engine list entry enables |
| unit_off | input | NU*OW | Engine source offsets |
| unit_inst | input | NU*IW | Engine instance numbers |
| eng_bit | input | 4 | Event bit checked for engines |
| prim_off | input | OW | Primary controller source offset |
| sec_off | input | OW | Secondary controller source offset |
| sec_present | input | 1 | Secondary controller exists |
| ctl_bit | input | 4 | Event bit checked for controllers |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write data (always zero) |
| mem_rdata | input | 8 | Read data, RD_LAT cycles after request |
| unit_hit | output | NU | Engine dispatch strobes |
| prim_hit | output | 1 | Primary controller dispatch strobe |
| sec_hit | output | 1 | Secondary controller dispatch strobe |
| busy | output | 1 | Scan in progress |
| err_flag | output | 1 | Anomaly held |
| err_value | output | 8 | Offending byte value |
| err_addr | output | AW | Offending byte address |
| err_ack | input | 1 | Clears the held anomaly |

## Verification
The bench builds the scanner with four engine entries, a two-bit instance field and a read latency of three. With these values every engine can sit on any of four distinct pages, and both the source wait and the status wait span several idle cycles. The random base addresses are 4 KiB aligned and chosen so that all four pages, plus the controllers on page 0, stay inside the 16-bit address space. As a result, page selection, skipped entries, the optional secondary controller and anomalous flag values can all occur together within a single scan.

// File: rtl/memirq_scan.sv
module memirq_scan #(
  parameter int NU     = 4,
  parameter int OW     = 6,
  parameter int IW     = 2,
  parameter int AW     = 16,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq,
  input  logic             region_valid,
  input  logic             per_inst,
  input  logic [AW-1:0]    region_base,
  input  logic [NU-1:0]    unit_en,
  input  logic [NU*OW-1:0] unit_off,
  input  logic [NU*IW-1:0] unit_inst,
  input  logic [3:0]       eng_bit,
  input  logic [OW-1:0]    prim_off,
  input  logic [OW-1:0]    sec_off,
  input  logic             sec_present,
  input  logic [3:0]       ctl_bit,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  output logic [NU-1:0]    unit_hit,
  output logic             prim_hit,
  output logic             sec_hit,
  output logic             busy,
  output logic             err_flag,
  output logic [7:0]       err_value,
  output logic [AW-1:0]    err_addr,
  input  logic             err_ack
);
  localparam int XW      = $clog2(NU + 3);
  localparam int CW      = $clog2(RD_LAT + 1);
  localparam int SRC_OFS = 1024;
  localparam logic [XW-1:0] IDX_PRIM = XW'(NU);
  localparam logic [XW-1:0] IDX_SEC  = XW'(NU + 1);
  localparam logic [XW-1:0] IDX_END  = XW'(NU + 2);

  typedef enum logic [2:0] {IDLE, PICK, SRD, SWT, SCLR, TRD, TWT, TCLR} st_t;

  st_t           st;
  logic [XW-1:0] idx;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;
  logic          pend;

  logic [OW-1:0] cur_off;
  logic [IW-1:0] cur_inst;
  logic [3:0]    cur_bit;
  logic          cur_ok;

  always_comb begin
    cur_off  = prim_off;
    cur_inst = '0;
    cur_bit  = ctl_bit;
    cur_ok   = (idx == IDX_PRIM);
    if (idx == IDX_SEC) begin
      cur_off = sec_off;
      cur_ok  = sec_present;
    end
    for (int i = 0; i < NU; i++) begin
      if (idx == XW'(i)) begin
        cur_off  = unit_off[i*OW +: OW];
        cur_inst = per_inst ? unit_inst[i*IW +: IW] : '0;
        cur_bit  = eng_bit;
        cur_ok   = unit_en[i];
      end
    end
  end

  wire [AW-1:0] page     = region_base + (AW'(cur_inst) << 12);
  wire [AW-1:0] src_addr = page + AW'(SRC_OFS) + AW'(cur_off);
  wire [AW-1:0] sta_addr = page + (AW'(cur_off) << 4) + AW'(cur_bit);
  wire          rd_done  = (cnt == CW'(RD_LAT - 1));
  wire          got      = (mem_rdata != 8'h00);
  wire          capture  = (st == SWT || st == TWT) && rd_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      idx  <= '0;
      cnt  <= '0;
      addr <= '0;
      pend <= 1'b0;
    end else begin
      if (irq && st != IDLE) pend <= 1'b1;
      case (st)
        IDLE: if (irq && region_valid) begin
          st  <= PICK;
          idx <= '0;
        end
        PICK: begin
          if (idx == IDX_END) begin
            pend <= 1'b0;
            if ((pend || irq) && region_valid) idx <= '0;
            else st <= IDLE;
          end else if (cur_ok) begin
            addr <= src_addr;
            st   <= SRD;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        SRD, TRD: begin
          cnt <= '0;
          st  <= (st == SRD) ? SWT : TWT;
        end
        SWT, TWT: begin
          if (!rd_done) cnt <= cnt + 1'b1;
          else if (got) st <= (st == SWT) ? SCLR : TCLR;
          else begin
            st  <= PICK;
            idx <= idx + 1'b1;
          end
        end
        SCLR: begin
          addr <= sta_addr;
          st   <= TRD;
        end
        TCLR: begin
          st  <= PICK;
          idx <= idx + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag  <= 1'b0;
      err_value <= '0;
      err_addr  <= '0;
    end else if (capture && got && mem_rdata != 8'hFF && !err_flag) begin
      err_flag  <= 1'b1;
      err_value <= mem_rdata;
      err_addr  <= addr;
    end else if (err_ack) begin
      err_flag <= 1'b0;
    end
  end

  assign busy      = (st != IDLE);
  assign mem_req   = (st == SRD) || (st == TRD) || (st == SCLR) || (st == TCLR);
  assign mem_we    = (st == SCLR) || (st == TCLR);
  assign mem_addr  = addr;
  assign mem_wdata = 8'h00;

  for (genvar g = 0; g < NU; g++) begin : g_hit
    assign unit_hit[g] = (st == TCLR) && (idx == XW'(g));
  end
  assign prim_hit = (st == TCLR) && (idx == IDX_PRIM);
  assign sec_hit  = (st == TCLR) && (idx == IDX_SEC);
endmodule

module memirq_scan_chk #(
  parameter int NU = 4,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          region_valid,
  input logic          sec_present,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata,
  input logic [NU-1:0] unit_hit,
  input logic          prim_hit,
  input logic          sec_hit,
  input logic          busy,
  input logic          err_flag,
  input logic [7:0]    err_value,
  input logic [AW-1:0] err_addr,
  input logic          err_ack
);
  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req && mem_wdata == 8'h00);
  assert_clear_same_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr == $past(mem_addr));
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({unit_hit, prim_hit, sec_hit}));
  assert_sec_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sec_hit |-> sec_present);
  assert_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !region_valid) |=> !busy);
  assert_err_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> err_value != 8'h00 && err_value != 8'hFF);
  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_ack) |=> err_flag && $stable(err_value) && $stable(err_addr));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

bind memirq_scan memirq_scan_chk #(.NU(NU), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .region_valid(region_valid), .sec_present(sec_present),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .unit_hit(unit_hit), .prim_hit(prim_hit), .sec_hit(sec_hit), .busy(busy),
  .err_flag(err_flag), .err_value(err_value), .err_addr(err_addr), .err_ack(err_ack)
);

// File: tb/test_memirq_scan.sv
module test_memirq_scan;
  localparam int NU = 4, OW = 6, IW = 2, AW = 16, RD_LAT = 3;

  logic clk = 0, rst_n = 0, irq = 0, region_valid = 0, per_inst = 0;
  logic [AW-1:0] region_base = '0;
  logic [NU-1:0] unit_en = '0;
  logic [NU*OW-1:0] unit_off = '0;
  logic [NU*IW-1:0] unit_inst = '0;
  logic [3:0] eng_bit = '0, ctl_bit = '0;
  logic [OW-1:0] prim_off = '0, sec_off = '0;
  logic sec_present = 0, err_ack = 0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr, err_addr;
  logic [7:0] mem_wdata, mem_rdata, err_value;
  logic [NU-1:0] unit_hit;
  logic prim_hit, sec_hit, busy, err_flag;

  int checks = 0, fails = 0, rd_count = 0;
  logic [7:0] mem [int];
  logic [7:0] pipe [RD_LAT+1];
  int hitq[$], expq[$], clrq[$], keepa[$], keepv[$];
  bit exp_err; int exp_ev, exp_ea;

  always #10 clk = ~clk;

  memirq_scan #(.NU(NU), .OW(OW), .IW(IW), .AW(AW), .RD_LAT(RD_LAT)) i_memirq_scan (.*);

  function automatic int rd(int a);
    return mem.exists(a) ? int'(mem[a]) : 0;
  endfunction

  assign mem_rdata = pipe[RD_LAT];

  always @(negedge clk) begin
    for (int k = RD_LAT; k > 0; k--) pipe[k] <= pipe[k-1];
    pipe[0] <= 8'h00;
    if (rst_n && mem_req && mem_we) mem[int'(mem_addr)] = mem_wdata;
    if (rst_n && mem_req && !mem_we) begin
      pipe[0] <= 8'(rd(int'(mem_addr)));
      rd_count++;
    end
    if (rst_n) begin
      for (int i = 0; i < NU; i++) if (unit_hit[i]) hitq.push_back(i);
      if (prim_hit) hitq.push_back(NU);
      if (sec_hit) hitq.push_back(NU + 1);
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rnd_flag();
    int r = int'($urandom % 6);
    if (r < 2) return 0;
    if (r < 5) return 8'hFF;
    return 1 + int'($urandom % 254);
  endfunction

  // R3, R4, R5, R7: reference walk computed from the requirements
  task automatic predict();
    expq.delete(); clrq.delete(); keepa.delete(); keepv.delete();
    exp_err = 0;
    for (int u = 0; u < NU + 2; u++) begin
      int off, inst, b, pg, sa, ta, s, t;
      bit ok;
      if (u < NU) begin
        ok = unit_en[u]; off = int'(unit_off[u*OW +: OW]);
        inst = per_inst ? int'(unit_inst[u*IW +: IW]) : 0; b = int'(eng_bit);
      end else begin
        ok = (u == NU) || sec_present; off = int'(u == NU ? prim_off : sec_off);
        inst = 0; b = int'(ctl_bit);
      end
      if (!ok) continue;
      pg = int'(region_base) + inst * 4096;
      sa = pg + 1024 + off; ta = pg + off * 16 + b;
      s = rd(sa); t = rd(ta);
      if (s == 0) begin keepa.push_back(ta); keepv.push_back(t); continue; end
      clrq.push_back(sa);
      if (s != 8'hFF && !exp_err) begin exp_err = 1; exp_ev = s; exp_ea = sa; end
      if (t == 0) continue;
      clrq.push_back(ta);
      if (t != 8'hFF && !exp_err) begin exp_err = 1; exp_ev = t; exp_ea = ta; end
      expq.push_back(u);
    end
  endtask

  task automatic pulse_and_wait();
    int n = 0;
    hitq.delete();
    @(negedge clk) irq = 1;
    @(negedge clk) irq = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic verify(string tag);
    chk(hitq.size() == expq.size(), {tag, " R4 strobe count"}, hitq.size(), expq.size());
    for (int i = 0; i < expq.size() && i < hitq.size(); i++)
      chk(hitq[i] == expq[i], {tag, " R4 strobe order"}, hitq[i], expq[i]);
    for (int i = 0; i < clrq.size(); i++)
      chk(rd(clrq[i]) == 0, {tag, " R1 R3 R5 cleared"}, rd(clrq[i]), 0);
    for (int i = 0; i < keepa.size(); i++)
      chk(rd(keepa[i]) == keepv[i], {tag, " R2 status untouched"}, rd(keepa[i]), keepv[i]);
    chk(err_flag == exp_err, {tag, " R7 flag"}, err_flag, exp_err);
    if (exp_err) begin
      chk(err_value == 8'(exp_ev), {tag, " R7 value"}, err_value, exp_ev);
      chk(err_addr == AW'(exp_ea), {tag, " R7 addr"}, err_addr, exp_ea);
    end
  endtask

  task automatic ack();
    @(negedge clk) err_ack = 1;
    @(negedge clk) err_ack = 0;
  endtask

  task automatic random_cfg();
    int offs[NU+2];
    for (int u = 0; u < NU + 2; u++) offs[u] = u * 8 + int'($urandom % 8);
    for (int u = 0; u < NU; u++) begin
      unit_off[u*OW +: OW] = OW'(offs[u]);
      unit_inst[u*IW +: IW] = IW'($urandom);
    end
    prim_off = OW'(offs[NU]); sec_off = OW'(offs[NU+1]);
    unit_en = NU'($urandom); per_inst = 1'($urandom);
    sec_present = 1'($urandom); eng_bit = 4'($urandom); ctl_bit = 4'($urandom);
    region_base = AW'(($urandom % 4) << 12);
    region_valid = 1;
    mem.delete();
    for (int u = 0; u < NU + 2; u++)
      for (int p = 0; p < 4; p++) begin
        int pg = int'(region_base) + p * 4096;
        int bsel = (u < NU) ? int'(eng_bit) : int'(ctl_bit);
        mem[pg + 1024 + offs[u]] = 8'(rnd_flag());
        mem[pg + offs[u] * 16 + bsel] = 8'(rnd_flag());
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int r0;
    void'($urandom(32'd20240611));
    for (int k = 0; k <= RD_LAT; k++) pipe[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !mem_req && !err_flag && unit_hit == 0 && !prim_hit && !sec_hit,
        "R11 reset idle", {busy, mem_req, err_flag}, 0);

    // R6 unconfigured region
    random_cfg(); region_valid = 0; r0 = rd_count;
    pulse_and_wait();
    chk(rd_count == r0, "R6 no access", rd_count - r0, 0);
    chk(hitq.size() == 0, "R6 no strobe", hitq.size(), 0);

    // R9 missed pulses fold into one rescan (all-zero memory)
    mem.delete(); region_valid = 1; unit_en = '1; sec_present = 1; r0 = rd_count;
    hitq.delete();
    @(negedge clk) irq = 1;
    @(negedge clk) irq = 0;
    repeat (3) @(negedge clk);
    irq = 1; @(negedge clk) irq = 0;
    repeat (2) @(negedge clk);
    irq = 1; @(negedge clk) irq = 0;
    while (busy) @(negedge clk);
    chk(rd_count - r0 == 2 * (NU + 2), "R9 one rescan", rd_count - r0, 2 * (NU + 2));

    // R7 R8 directed anomaly hold and acknowledge
    random_cfg(); unit_en = 4'b0001; per_inst = 0;
    mem.delete();
    mem[int'(region_base) + 1024 + int'(unit_off[OW-1:0])] = 8'h5A;
    mem[int'(region_base) + int'(unit_off[OW-1:0]) * 16 + int'(eng_bit)] = 8'h33;
    predict(); pulse_and_wait(); verify("directed");
    chk(hitq.size() == 1, "R7 anomaly still dispatched", hitq.size(), 1);
    mem[int'(region_base) + 1024 + int'(prim_off)] = 8'h11;
    mem[int'(region_base) + int'(prim_off) * 16 + int'(ctl_bit)] = 8'hFF;
    pulse_and_wait();
    chk(err_value == 8'h5A, "R8 value kept", err_value, 8'h5A);
    chk(err_flag, "R8 flag kept", err_flag, 1);
    ack();
    chk(!err_flag, "R8 ack clears", err_flag, 0);

    // random trials, R2 R3 R4 R5 R10 through data agreement
    for (int t = 0; t < 40; t++) begin
      random_cfg();
      ack();
      predict();
      pulse_and_wait();
      verify("random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule